// File: doc/BRIEF.md
# NAND Flash Command Sequencer

A host loads address and data registers, then writes one 32-bit control word with its start bit set. The engine turns that word into NAND bus cycles on the flash pins: chip enable, command latch, address latch, write and read strobes, and an 8-bit data bus. Flag bits in the control word pick which phases run in a given start, and the phases always run in a fixed order. The first command comes first, then the address cycles, then the second command, a wait for the flash to become ready, and finally the data beats.

A chip-enable hold flag keeps the flash selected after a start ends, so that a long transfer can be split into many single-word starts. Five programmable counts set the strobe widths, the setup and hold around each byte, and the delay between a second command and sampling of the ready/busy pin. A geometry register sets the number of column and row address bytes.

Top module: `nand_cmd_sequencer`

Register offsets on `reg_addr` / `reg_raddr`: 0 control/status, 1 column, 2 row, 3 data, 4 wait counts, 5 geometry.

## Requirements
- R1: After reset, CE# is high, WE# and RE# are high, CLE and ALE are low, the data bus is not driven, and control offset 0 reads 32'h0400_0000 while the ready pin is high.
- R2: Within one start, the enabled phases run in this order: first command byte (flag bit 16, opcode in bits 7:0, sent with CLE), column address bytes (bit 17, sent with ALE), row address bytes (bit 18, sent with ALE), second command byte (bit 19, opcode in bits 15:8, sent with CLE).
- R3: The column phase sends geometry bits 5:4 plus one bytes of the column register, and the row phase sends geometry bits 7:6 plus one bytes of the row register, each least significant byte first.
- R4: With bit 24 set, a single 0x00 address byte follows the first command, and the column and row phases are skipped even if their flags are set.
- R5: Bit 31 of the control word starts an operation. It reads as 1 from the first read after the start write until the bus sequence ends, then reads 0.
- R6: With bit 30 set, CE# stays low after the operation ends, and a following start does not raise it. A start with bit 30 clear raises CE# at its end.
- R7: A write start (bit 21) sends control bits 29:28 plus one bytes of the data register, least significant byte first, each with a WE# strobe and neither CLE nor ALE.
- R8: A read start (bit 20) takes bits 29:28 plus one bytes with RE# strobes, puts byte k into data bits 8k+7:8k and clears the bytes above. The data register then keeps that value through later starts that move no data.
- R9: WE# and RE# each stay low for max(wait field 0, 1) clocks, where field 0 is bits 5:0 of the wait-count register. The fields for high width, setup, hold and ready delay sit at bits 11:6, 17:12, 23:18 and 29:24.
- R10: After a second command, the engine waits max(field 4, 1) clocks and then until the ready pin is high before it goes on. Control bit 26 reads the live level of the ready pin.
- R11: A control write made while an operation runs has no effect on that operation, and it does not change the stored control word.
- R12: A start with both bit 20 and bit 21 set moves no data and sets error bit 27. The next start that does not set both bits clears it.
- R13: A start with the reset opcode 0xFF and bit 30 clear pulls CE# low for the command cycle and raises it again at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Data bus value driven to the flash |
| nand_io_oe | output | 1 | Data bus output enable |
| nand_io_in | input | 8 | Data bus value from the flash |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The start write is registered, so the busy bit is due on the first register read one clock after the write. Each byte then takes setup, low, high and hold counts plus one idle clock, and the bus is idle for one clock before the busy bit drops. Because these totals depend on the programmed counts, the bench does not expect results at fixed cycles. It polls the busy bit at falling edges and compares the byte log captured on each strobe's rising edge. Strobe widths are counted in clocks at falling edges and compared with the programmed low count. Ready-pin gating is checked by holding the pin low for far longer than the ready delay and confirming that the busy bit stays set.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int TW = 6;   // width of one timing count
    localparam int DW = 32;  // register width

    typedef enum logic [3:0] {
        PH_IDLE, PH_CMD1, PH_SPEC, PH_COL, PH_ROW,
        PH_CMD2, PH_WTB, PH_WRB, PH_DATA, PH_END
    } phase_e;

    typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} bkind_e;

    typedef enum logic [2:0] {BS_IDLE, BS_SETUP, BS_LOW, BS_HIGH, BS_HOLD} bstate_e;

    typedef struct packed {
        logic       go;
        logic       hold;
        logic [1:0] nbytes;
        logic [2:0] rsv_hi;
        logic       spec;
        logic [1:0] rsv_mid;
        logic       wr;
        logic       rd;
        logic       cmd2;
        logic       row;
        logic       col;
        logic       cmd1;
        logic [7:0] op2;
        logic [7:0] op1;
    } ctrl_t;

    typedef struct packed {
        logic [1:0]    rsv;
        logic [TW-1:0] wb;
        logic [TW-1:0] hold;
        logic [TW-1:0] setup;
        logic [TW-1:0] high;
        logic [TW-1:0] low;
    } wait_t;

    // counter reload value: a zero count still lasts one clock
    function automatic logic [TW-1:0] cnt_load(logic [TW-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    // first enabled phase strictly after cur
    function automatic phase_e next_phase(phase_e cur, ctrl_t c);
        if (cur < PH_CMD1 && c.cmd1)            return PH_CMD1;
        if (cur < PH_SPEC && c.spec)            return PH_SPEC;
        if (cur < PH_COL && c.col && !c.spec)   return PH_COL;
        if (cur < PH_ROW && c.row && !c.spec)   return PH_ROW;
        if (cur < PH_CMD2 && c.cmd2)            return PH_CMD2;
        if (cur < PH_WTB && c.cmd2)             return PH_WTB;
        if (cur < PH_DATA && (c.rd ^ c.wr))     return PH_DATA;
        return PH_END;
    endfunction

endpackage

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bkind_e     kind,
    input  logic [7:0] byte_in,
    input  wait_t      tm,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       done,
    output logic [7:0] rd_byte
);
    bstate_e       st;
    logic [TW-1:0] cnt;
    bkind_e        kind_q;
    logic [7:0]    byte_q;
    logic          unused_tm;

    assign unused_tm = ^{tm.rsv, tm.wb};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= BS_IDLE;
            cnt     <= '0;
            kind_q  <= BK_CMD;
            byte_q  <= '0;
            done    <= 1'b0;
            rd_byte <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                BS_IDLE: if (start) begin
                    st     <= BS_SETUP;
                    cnt    <= cnt_load(tm.setup);
                    kind_q <= kind;
                    byte_q <= byte_in;
                end
                BS_SETUP: if (cnt == '0) begin
                    st  <= BS_LOW;
                    cnt <= cnt_load(tm.low);
                end else cnt <= cnt - 1'b1;
                BS_LOW: if (cnt == '0) begin
                    st  <= BS_HIGH;
                    cnt <= cnt_load(tm.high);
                    if (kind_q == BK_RD) rd_byte <= io_in;
                end else cnt <= cnt - 1'b1;
                BS_HIGH: if (cnt == '0) begin
                    st  <= BS_HOLD;
                    cnt <= cnt_load(tm.hold);
                end else cnt <= cnt - 1'b1;
                BS_HOLD: if (cnt == '0) begin
                    st   <= BS_IDLE;
                    done <= 1'b1;
                end else cnt <= cnt - 1'b1;
                default: st <= BS_IDLE;
            endcase
        end
    end

    assign cle    = (st != BS_IDLE) && (kind_q == BK_CMD);
    assign ale    = (st != BS_IDLE) && (kind_q == BK_ADDR);
    assign io_oe  = (st != BS_IDLE) && (kind_q != BK_RD);
    assign we_n   = !((st == BS_LOW) && (kind_q != BK_RD));
    assign re_n   = !((st == BS_LOW) && (kind_q == BK_RD));
    assign io_out = byte_q;

    // R9: the two strobes are never low together
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    // R2: the sequencer only requests a byte when this engine is free
    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> (st == BS_IDLE));
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  ctrl_t         ctrl,
    input  logic [3:0]    geom_n,
    input  logic [DW-1:0] col_addr,
    input  logic [DW-1:0] row_addr,
    input  logic [DW-1:0] wdata,
    input  logic [TW-1:0] wb_cnt,
    input  logic          rb,
    input  logic          bc_done,
    input  logic [7:0]    bc_rd_byte,
    output logic          bc_start,
    output bkind_e        bc_kind,
    output logic [7:0]    bc_byte,
    output logic          busy,
    output logic          ce_n,
    output logic          err,
    output logic          rd_valid,
    output logic [DW-1:0] rd_word
);
    phase_e        ph;
    logic [1:0]    idx;
    logic [1:0]    last_idx;
    logic          issued;
    logic          is_byte_ph;
    logic [TW-1:0] wcnt;
    logic [DW-1:0] acc;
    logic [DW-1:0] src;
    logic          ce_act;
    logic          unused_ctrl;

    assign unused_ctrl = ^{ctrl.go, ctrl.rsv_hi, ctrl.rsv_mid};

    always_comb begin
        last_idx = 2'd0;
        src      = '0;
        bc_kind  = BK_ADDR;
        unique case (ph)
            PH_CMD1: begin src = {24'b0, ctrl.op1}; bc_kind = BK_CMD; end
            PH_CMD2: begin src = {24'b0, ctrl.op2}; bc_kind = BK_CMD; end
            PH_COL:  begin src = col_addr; last_idx = geom_n[1:0]; end
            PH_ROW:  begin src = row_addr; last_idx = geom_n[3:2]; end
            PH_DATA: begin
                src      = wdata;
                last_idx = ctrl.nbytes;
                bc_kind  = ctrl.rd ? BK_RD : BK_WR;
            end
            default: ;
        endcase
    end

    assign bc_byte    = src[{idx, 3'b000} +: 8];
    assign is_byte_ph = (ph == PH_CMD1) || (ph == PH_SPEC) || (ph == PH_COL) ||
                        (ph == PH_ROW) || (ph == PH_CMD2) || (ph == PH_DATA);
    assign bc_start   = is_byte_ph && !issued;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            idx      <= '0;
            issued   <= 1'b0;
            wcnt     <= '0;
            acc      <= '0;
            ce_act   <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (bc_start) issued <= 1'b1;
            unique case (ph)
                PH_IDLE: if (go) begin
                    ph     <= next_phase(PH_IDLE, ctrl);
                    ce_act <= 1'b1;
                    err    <= ctrl.rd & ctrl.wr;
                    acc    <= '0;
                    idx    <= '0;
                    issued <= 1'b0;
                end
                PH_WTB: if (wcnt == '0) ph <= PH_WRB;
                        else wcnt <= wcnt - 1'b1;
                PH_WRB: if (rb) ph <= next_phase(PH_WRB, ctrl);
                PH_END: begin
                    ce_act <= ctrl.hold;
                    ph     <= PH_IDLE;
                end
                default: if (bc_done) begin
                    issued <= 1'b0;
                    if (ph == PH_DATA && ctrl.rd) acc[{idx, 3'b000} +: 8] <= bc_rd_byte;
                    if (idx == last_idx) begin
                        idx <= '0;
                        ph  <= next_phase(ph, ctrl);
                        if (ph == PH_CMD2) wcnt <= cnt_load(wb_cnt);
                        if (ph == PH_DATA && ctrl.rd) rd_valid <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign ce_n    = !ce_act;
    assign rd_word = acc;

    // R10: no progress past the ready wait while the flash is busy
    p_wait_rb_r10: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WRB && !rb) |=> (ph == PH_WRB));
    // R13: chip enable is low for every cycle of a running operation
    p_ce_active_r13: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE) |-> !ce_n);
    // R11: a start request only reaches an idle sequencer
    p_go_idle_r11: assert property (@(posedge clk) disable iff (rst)
        go |-> (ph == PH_IDLE));
    // R12: a conflicting start never enters the data phase
    p_no_data_err_r12: assert property (@(posedge clk) disable iff (rst)
        (err && ph != PH_IDLE) |-> (ph != PH_DATA));
endmodule

// File: rtl/nand_cmd_sequencer.sv
module nand_cmd_sequencer
    import nfc_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [DW-1:0]     reg_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb
);
    localparam logic [REG_AW-1:0] A_CTRL = 'd0;
    localparam logic [REG_AW-1:0] A_COL  = 'd1;
    localparam logic [REG_AW-1:0] A_ROW  = 'd2;
    localparam logic [REG_AW-1:0] A_DATA = 'd3;
    localparam logic [REG_AW-1:0] A_WAIT = 'd4;
    localparam logic [REG_AW-1:0] A_GEOM = 'd5;

    ctrl_t         ctrl_q;
    wait_t         wait_q;
    logic [DW-1:0] col_q, row_q, data_q;
    logic [7:0]    geom_q;
    logic          go_q, seq_busy, busy_all, seq_err, rd_valid;
    logic [DW-1:0] rd_word;
    logic          bc_start, bc_done;
    bkind_e        bc_kind;
    logic [7:0]    bc_byte, bc_rd_byte;

    assign busy_all = go_q | seq_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            wait_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            data_q <= '0;
            geom_q <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CTRL: if (!busy_all) begin
                        ctrl_q <= reg_wdata;
                        go_q   <= reg_wdata[31];
                    end
                    A_COL:  col_q  <= reg_wdata;
                    A_ROW:  row_q  <= reg_wdata;
                    A_DATA: data_q <= reg_wdata;
                    A_WAIT: wait_q <= reg_wdata;
                    A_GEOM: geom_q <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (rd_valid) data_q <= rd_word;
        end
    end

    always_comb begin
        unique case (reg_raddr)
            A_CTRL:  reg_rdata = {busy_all, ctrl_q.hold, ctrl_q.nbytes, seq_err,
                                  nand_rb, ctrl_q[25:0]};
            A_COL:   reg_rdata = col_q;
            A_ROW:   reg_rdata = row_q;
            A_DATA:  reg_rdata = data_q;
            A_WAIT:  reg_rdata = wait_q;
            A_GEOM:  reg_rdata = {24'b0, geom_q};
            default: reg_rdata = '0;
        endcase
    end

    nfc_seq i_seq (
        .clk(clk), .rst(rst), .go(go_q), .ctrl(ctrl_q), .geom_n(geom_q[7:4]),
        .col_addr(col_q), .row_addr(row_q), .wdata(data_q), .wb_cnt(wait_q.wb),
        .rb(nand_rb), .bc_done(bc_done), .bc_rd_byte(bc_rd_byte),
        .bc_start(bc_start), .bc_kind(bc_kind), .bc_byte(bc_byte),
        .busy(seq_busy), .ce_n(nand_ce_n), .err(seq_err),
        .rd_valid(rd_valid), .rd_word(rd_word)
    );

    nfc_bus_cycle i_bus (
        .clk(clk), .rst(rst), .start(bc_start), .kind(bc_kind), .byte_in(bc_byte),
        .tm(wait_q), .io_in(nand_io_in), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .io_out(nand_io_out),
        .io_oe(nand_io_oe), .done(bc_done), .rd_byte(bc_rd_byte)
    );

    // R11: control writes during a running operation leave the stored word alone
    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && busy_all) |=> $stable(ctrl_q));
    // R8: the data register changes only through a host write or a finished read
    p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !(reg_wr && reg_addr == A_DATA)) |=> $stable(data_q));
endmodule

// File: tb/test_nand_cmd_sequencer.sv
module test_nand_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb = 1'b1;

    int checks = 0, errors = 0;
    int rdidx = 0;
    int logn = 0;
    int          ev_kind [0:255];
    logic [7:0]  ev_val  [0:255];
    int lowcnt = 0, wmin = 1000, wmax = 0, cefall = 0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_ce = 1'b1;
    logic [7:0] rd_last = '0;

    always #10 clk = ~clk;

    nand_cmd_sequencer i_nand_cmd_sequencer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    // flash model: successive read bytes are A0, A1, ...
    assign nand_io_in = 8'hA0 + rdidx[7:0];
    always @(posedge nand_re_n) if (!rst) rdidx <= rdidx + 1;

    // pin monitor, sampled at falling edges; kinds 0 cmd, 1 addr, 2 write, 3 read
    always @(negedge clk) begin
        if (!nand_re_n) rd_last = nand_io_in;
        if (!prev_we && nand_we_n && logn < 256) begin
            ev_kind[logn] = nand_cle ? 0 : (nand_ale ? 1 : 2);
            ev_val[logn]  = nand_io_out;
            logn++;
        end
        if (!prev_re && nand_re_n && logn < 256) begin
            ev_kind[logn] = 3;
            ev_val[logn]  = rd_last;
            logn++;
        end
        if (!nand_we_n || !nand_re_n) lowcnt++;
        else if (lowcnt != 0) begin
            if (lowcnt < wmin) wmin = lowcnt;
            if (lowcnt > wmax) wmax = lowcnt;
            lowcnt = 0;
        end
        if (prev_ce && !nand_ce_n) cefall++;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        prev_ce = nand_ce_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        int n = 0;
        do begin rreg(3'd0, s); n++; end while (s[31] && n < 5000);
        chk({req, " start bit clears"}, {31'b0, s[31]}, 32'h0);
    endtask

    task automatic chk_ev(input string req, input int base, input int i,
                          input int kind, input logic [7:0] val);
        chk(req, {22'b0, ev_kind[base+i][1:0], ev_val[base+i]}, {22'b0, kind[1:0], val});
    endtask

    task automatic t_reset;
        logic [31:0] s;
        rreg(3'd0, s);
        chk("R1 status", s, 32'h0400_0000);
        chk("R1 pins", {26'b0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe},
            32'b111000);
    endtask

    task automatic t_page_addr;
        logic [31:0] s;
        int b;
        wreg(3'd5, 32'h90);          // 2 column bytes, 3 row bytes
        wreg(3'd1, 32'h1234);
        wreg(3'd2, 32'h0056_789A);
        b = logn;
        wreg(3'd0, 32'h800F_3000);   // cmd1 00, col, row, cmd2 30
        rreg(3'd0, s);
        chk("R5 busy after start", {31'b0, s[31]}, 32'h1);
        wait_done("R5");
        chk("R2 event count", logn - b, 7);
        chk_ev("R2 first cmd", b, 0, 0, 8'h00);
        chk_ev("R3 col lsb", b, 1, 1, 8'h34);
        chk_ev("R3 col msb", b, 2, 1, 8'h12);
        chk_ev("R3 row b0", b, 3, 1, 8'h9A);
        chk_ev("R3 row b1", b, 4, 1, 8'h78);
        chk_ev("R3 row b2", b, 5, 1, 8'h56);
        chk_ev("R2 second cmd", b, 6, 0, 8'h30);
    endtask

    task automatic t_spec;
        int b = logn;
        wreg(3'd0, 32'h8107_0090);   // id read, column/row flags ignored
        wait_done("R4");
        chk("R4 event count", logn - b, 2);
        chk_ev("R4 cmd", b, 0, 0, 8'h90);
        chk_ev("R4 zero address", b, 1, 1, 8'h00);
    endtask

    task automatic t_write;
        int b;
        wreg(3'd3, 32'hDDCC_BBAA);
        b = logn;
        wreg(3'd0, 32'hB020_0000);
        wait_done("R7");
        chk("R7 word count", logn - b, 4);
        chk_ev("R7 b0", b, 0, 2, 8'hAA);
        chk_ev("R7 b3", b, 3, 2, 8'hDD);
        b = logn;
        wreg(3'd0, 32'h9020_0000);
        wait_done("R7");
        chk("R7 two-byte count", logn - b, 2);
        chk_ev("R7 b1", b, 1, 2, 8'hBB);
    endtask

    task automatic t_read;
        logic [31:0] d, exp;
        int r0 = rdidx;
        exp = {8'hA0 + 8'(r0 + 3), 8'hA0 + 8'(r0 + 2), 8'hA0 + 8'(r0 + 1), 8'hA0 + 8'(r0)};
        wreg(3'd0, 32'hB010_0000);
        wait_done("R8");
        rreg(3'd3, d);
        chk("R8 word read", d, exp);
        r0 = rdidx;
        wreg(3'd0, 32'h8010_0000);
        wait_done("R8");
        rreg(3'd3, d);
        chk("R8 single byte", d, {24'b0, 8'hA0 + 8'(r0)});
        exp = d;
        wreg(3'd0, 32'h8001_0070);   // command only
        wait_done("R8");
        rreg(3'd3, d);
        chk("R8 data held", d, exp);
    endtask

    task automatic t_timing;
        wreg(3'd4, (32'd1 << 18) | (32'd1 << 12) | (32'd2 << 6) | 32'd3);
        wmin = 1000; wmax = 0;
        wreg(3'd0, 32'hB010_0000);
        wait_done("R9");
        chk("R9 low min", wmin, 3);
        chk("R9 low max", wmax, 3);
        wreg(3'd4, 32'h0);
        wmin = 1000; wmax = 0;
        wreg(3'd0, 32'h8001_0070);
        wait_done("R9");
        chk("R9 zero count width", wmin, 1);
    endtask

    task automatic t_ready;
        logic [31:0] s;
        int b = logn;
        wreg(3'd4, 32'd5 << 24);
        nand_rb = 1'b0;
        wreg(3'd0, 32'h8009_D060);
        repeat (200) @(negedge clk);
        rreg(3'd0, s);
        chk("R10 busy while flash busy", {30'b0, s[31], s[26]}, 32'h2);
        wreg(3'd0, 32'h8001_00EE);   // ignored: operation still running
        nand_rb = 1'b1;
        wait_done("R10");
        rreg(3'd0, s);
        chk("R10 ready bit live", {31'b0, s[26]}, 32'h1);
        chk("R11 no extra cycles", logn - b, 2);
        chk_ev("R11 cmd2 kept", b, 1, 0, 8'hD0);
        chk("R11 stored word", {12'b0, s[19:0]}, 32'h0009_D060);
    endtask

    task automatic t_hold;
        int f;
        wreg(3'd0, 32'hC001_0070);
        wait_done("R6");
        chk("R6 ce held", {31'b0, nand_ce_n}, 32'h0);
        f = cefall;
        wreg(3'd0, 32'h8010_0000);
        wait_done("R6");
        chk("R6 no new fall", cefall - f, 0);
        chk("R6 ce released", {31'b0, nand_ce_n}, 32'h1);
    endtask

    task automatic t_err;
        logic [31:0] s;
        int b = logn;
        wreg(3'd0, 32'hB030_0000);
        wait_done("R12");
        rreg(3'd0, s);
        chk("R12 error set", {31'b0, s[27]}, 32'h1);
        chk("R12 no beats", logn - b, 0);
        wreg(3'd0, 32'h8001_0070);
        wait_done("R12");
        rreg(3'd0, s);
        chk("R12 error cleared", {31'b0, s[27]}, 32'h0);
    endtask

    task automatic t_reset_op;
        int f = cefall;
        int b = logn;
        wreg(3'd0, 32'h8001_00FF);
        wait_done("R13");
        chk("R13 ce pulsed", cefall - f, 1);
        chk_ev("R13 reset opcode", b, 0, 0, 8'hFF);
        chk("R13 ce released", {31'b0, nand_ce_n}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page_addr();
        t_spec();
        t_write();
        t_read();
        t_timing();
        t_ready();
        t_hold();
        t_err();
        t_reset_op();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule